// File: doc/BRIEF.md
# Octal Driver Serial Command Port

This block is the slave side of a four-wire synchronous serial link that controls a bank of high-side output drivers. A master pulls the active-low select low, toggles the serial clock and streams one command bit per channel into the port; at the same time the port streams out a snapshot of the per-channel diagnostic levels taken when the select went low. When the select returns high, the received word becomes the new parallel command for all drivers at once, provided the number of clock pulses in the frame was a whole, nonzero number of frames.

The serial clock, select and data inputs are treated as asynchronous and are sampled by a faster system clock through a synchronizer of configurable depth. Both data capture and data launch happen on the rising serial clock edge. Channel 1 (bit 0) travels first in both directions. Because the receive and transmit paths share one shift register, bits clocked beyond one frame length emerge on the data output delayed by one frame, so several ports can be chained, and a master that can only send longer bursts simply prepends dummy bits. A one-cycle pulse marks every accepted frame for the fault controller, which uses it to release a latched thermal fault.

Top module: `octal_cmd_port`

## Requirements
- R1: After reset `cmd_o` is all zeros; `sdo_oe` is low whenever the select is inactive (high) and high while it is active.
- R2: The falling edge of `sel_n` copies `diag_in` into the transmit path; changes on `diag_in` after that edge do not alter the bits sent in that frame.
- R3: Right after `sel_n` falls and before any serial clock edge, `sdo` already carries snapshot bit 0 (channel 1).
- R4: Each rising `sclk` edge while selected samples `sdi` and advances `sdo` to the next snapshot bit; after k rising edges (k < WIDTH) `sdo` shows snapshot bit k.
- R5: After WIDTH or more rising edges, `sdo` shows the `sdi` bits received WIDTH edges earlier, first-received first.
- R6: When `sel_n` rises after a nonzero count of rising edges that is a multiple of WIDTH, `cmd_o` takes the received word in one step, the first-received of the last WIDTH bits landing in bit 0, and `frame_ok` is high for exactly one system clock.
- R7: In a frame of 2·WIDTH or 3·WIDTH edges only the final WIDTH bits form the command.
- R8: A frame whose edge count is zero or not a multiple of WIDTH leaves `cmd_o` unchanged and produces no `frame_ok` pulse.
- R9: `sclk` and `sdi` activity while the select is inactive has no effect on `cmd_o`, `frame_ok`, or the edge count of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high |
| sel_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from master |
| diag_in | input | WIDTH | Per-channel actual output levels |
| sdo | output | 1 | Serial data to master |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| cmd_o | output | WIDTH | Parallel driver command |
| frame_ok | output | 1 | One-cycle pulse on each accepted frame |

## Verification
The bench builds the port with WIDTH = 4 and the default two-stage synchronizer. The narrow word makes it practical to send every command value against every diagnostic value, 256 frames in all, checking every bit seen on `sdo` and the resulting command. The same width keeps the frame-length sweep short: every edge count from zero to twelve is exercised, covering rejected partial frames and the double and triple lengths where only the last word counts.

// File: rtl/octal_cmd_port.sv
module octal_cmd_port #(
  parameter int WIDTH = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sel_n,
  input  logic             sdi,
  input  logic [WIDTH-1:0] diag_in,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [WIDTH-1:0] cmd_o,
  output logic             frame_ok
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;

  logic [SYNC-1:0]  sclk_q, sel_q, sdi_q;
  logic             sclk_d, sel_d;
  logic [WIDTH-1:0] sr;
  logic [CW-1:0]    cnt;
  logic             seen;

  wire sclk_now = sclk_q[SYNC-1];
  wire sel_now  = sel_q[SYNC-1];
  wire sdi_now  = sdi_q[SYNC-1];

  wire sel_fall = sel_d & ~sel_now;
  wire sel_rise = ~sel_d & sel_now;
  wire sh_edge  = ~sel_d & ~sel_now & sclk_now & ~sclk_d;
  wire good     = seen && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '1;
      sel_q  <= '1;
      sdi_q  <= '0;
      sclk_d <= 1'b1;
      sel_d  <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC-2:0], sclk};
      sel_q  <= {sel_q[SYNC-2:0], sel_n};
      sdi_q  <= {sdi_q[SYNC-2:0], sdi};
      sclk_d <= sclk_now;
      sel_d  <= sel_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      cnt  <= '0;
      seen <= 1'b0;
    end else if (sel_fall) begin
      sr   <= diag_in;
      cnt  <= '0;
      seen <= 1'b0;
    end else if (sh_edge) begin
      sr   <= {sdi_now, sr[WIDTH-1:1]};
      cnt  <= (cnt == CW'(WIDTH - 1)) ? '0 : cnt + 1'b1;
      seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o    <= '0;
      frame_ok <= 1'b0;
    end else begin
      frame_ok <= sel_rise && good;
      if (sel_rise && good) cmd_o <= sr;
    end
  end

  assign sdo    = sr[0];
  assign sdo_oe = ~sel_d;

  assert_cmd_moves_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |-> frame_ok);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  assert_pulse_when_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> !sdo_oe);

  assert_idle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && $past(!sdo_oe)) |-> $stable(sr));

  assert_count_cleared_on_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (cnt == '0 && !seen));

endmodule

// File: tb/test_octal_cmd_port.sv
module test_octal_cmd_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n, sclk, sel_n, sdi;
  logic [W-1:0] diag_in, cmd_o;
  logic sdo, sdo_oe, frame_ok;

  int vectors = 0;
  int miscompares = 0;
  int pulses = 0;
  logic [63:0] tx, rx;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && frame_ok) pulses++;

  octal_cmd_port #(.WIDTH(W), .SYNC(2)) i_octal_cmd_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
    .diag_in(diag_in), .sdo(sdo), .sdo_oe(sdo_oe), .cmd_o(cmd_o),
    .frame_ok(frame_ok));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_frame(input int n, input logic [W-1:0] d);
    diag_in = d;
    @(negedge clk);
    sel_n = 1'b0;
    repeat (20) @(negedge clk);
    diag_in = ~d;
    rx = '0;
    rx[0] = sdo;
    check(sdo_oe == 1'b1, "R1 enable while selected", int'(sdo_oe), 1);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      sdi  = tx[i];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      rx[i+1] = sdo;
    end
    sel_n = 1'b1;
    repeat (20) @(negedge clk);
    check(sdo_oe == 1'b0, "R1 high impedance when idle", int'(sdo_oe), 0);
  endtask

  task automatic check_stream(input int n, input logic [W-1:0] d);
    for (int k = 0; k <= n; k++) begin
      logic e;
      e = (k < W) ? d[k] : tx[k-W];
      if (k == 0)      check(rx[k] == e, "R3 first bit before clock", int'(rx[k]), int'(e));
      else if (k < W)  check(rx[k] == e, "R4 diag shift order / R2 snapshot", int'(rx[k]), int'(e));
      else             check(rx[k] == e, "R5 delayed pass-through", int'(rx[k]), int'(e));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    int p0;
    rst_n = 1'b0; sclk = 1'b1; sel_n = 1'b1; sdi = 1'b0; diag_in = '0; tx = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(cmd_o == '0, "R1 reset command", int'(cmd_o), 0);
    check(sdo_oe == 1'b0, "R1 reset enable", int'(sdo_oe), 0);
    check(pulses == 0, "R6 no pulse at reset", pulses, 0);

    // R6 / R2 / R3 / R4: every command against every diagnostic word
    for (int c = 0; c < (1 << W); c++) begin
      for (int d = 0; d < (1 << W); d++) begin
        p0 = pulses;
        tx = 64'(c);
        do_frame(W, W'(d));
        check_stream(W, W'(d));
        check(cmd_o == W'(c), "R6 command applied", int'(cmd_o), c);
        check(pulses == p0 + 1, "R6 one pulse", pulses - p0, 1);
      end
    end

    // R7 / R8: frame length sweep 0..3W
    for (int n = 0; n <= 3 * W; n++) begin
      logic [W-1:0] exp;
      prev = cmd_o;
      p0 = pulses;
      tx = 64'hA5C3_96E1_7B2D_4F08 ^ 64'(n * 37);
      do_frame(n, W'(n * 5 + 3));
      check_stream(n, W'(n * 5 + 3));
      if (n != 0 && (n % W) == 0) begin
        exp = tx[n-W +: W];
        check(cmd_o == exp, "R7 last word wins", int'(cmd_o), int'(exp));
        check(pulses == p0 + 1, "R7 pulse on long frame", pulses - p0, 1);
      end else begin
        check(cmd_o == prev, "R8 partial frame keeps command", int'(cmd_o), int'(prev));
        check(pulses == p0, "R8 no pulse on partial frame", pulses - p0, 0);
      end
    end

    // R9: clocks while idle are ignored
    prev = cmd_o;
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; sdi = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
    end
    check(cmd_o == prev, "R9 idle clocks keep command", int'(cmd_o), int'(prev));
    check(pulses == p0, "R9 idle clocks no pulse", pulses - p0, 0);
    check(sdo_oe == 1'b0, "R9 idle keeps high impedance", int'(sdo_oe), 0);
    tx = 64'(~prev);
    do_frame(W, W'(9));
    check_stream(W, W'(9));
    check(cmd_o == ~prev, "R9 next frame counts from zero", int'(cmd_o), int'(~prev));
    check(pulses == p0 + 1, "R9 next frame pulses", pulses - p0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule